// File: doc/BRIEF.md
# Protected SRAM Controller with Selectable Latency

This block is an on-chip RAM controller that sits on a simple single-request internal bus. It serves a data array split into equal regions, and a small bank of control registers. Bus masters read and write bytes, aligned half-words or words. Every access passes a permission check. The array regions are checked against per-region attribute bits. The registers are checked against a fixed supervisor-and-data rule. A failed check never changes storage and returns zero data. It also raises one of two error pulses, chosen by whether the main CPU or another master issued the access.

Each access completes in one cycle by default. A mode bit in the control registers adds one wait cycle. A small state machine sequences the access through three states. `ST_IDLE` waits for a strobe. `ST_HOLD` is the extra cycle of two-cycle mode. `ST_RESP` is the cycle in which the response is presented. The transitions are:
- accept-fast: `ST_IDLE` to `ST_RESP`.
- accept-slow: `ST_IDLE` to `ST_HOLD`.
- finish-wait: `ST_HOLD` to `ST_RESP`.
- retire: `ST_RESP` to `ST_IDLE`.
- stay-idle: `ST_IDLE` to `ST_IDLE`, taken when no strobe is present.

The array is `NUM_REGIONS` × `REGION_BYTES` bytes. The default is two 1-KB regions; deployment uses 8 KB per region. It occupies addresses with the top address bit at 0. The register space sits at the top address bit set to 1. It has 16 word slots, selected by address bits [5:2].

Top module: `guarded_sram_ctrl`

## Requirements
- R1: After reset, `rsp_ready`, `err_dsi`, `err_mce` and `rsp_rdata` are 0. All registers read as 0, so the block starts in one-cycle mode with no region attributes set.
- R2: In one-cycle mode, a strobe sampled at a rising edge in `ST_IDLE` gives `rsp_ready` high for exactly the one cycle after that edge.
- R3: Bit 0 of register slot 0 selects two-cycle mode. When it is 1, `rsp_ready` rises one cycle later than in R2, with identical results. A change takes effect from the next access.
- R4: The size codes are 0 for byte, 1 for half-word and 2 for word. Byte lanes are big-endian: byte offset k occupies bits [31-8k -: 8]. A read returns the addressed bytes in their lanes with the other lanes zero. A write updates only the addressed lanes. `rsp_rdata` is zero whenever `rsp_ready` is low, and for writes.
- R5: Size code 3 is an error. So is a half-word at an odd address, and a word whose address bits [1:0] are not 00.
- R6: Register slot 1 holds 3 bits per region r at bits [3r+2:3r]. These are {supervisor-only, data-only, read-only}. The bits apply only while `xlate_en` is 1. When they apply, the following are errors: a write to a read-only region, an instruction access to a data-only region, and a user access to a supervisor-only region.
- R7: Any register access with `req_super` = 0 or `req_data` = 0 is an error.
- R8: Register slots 12 to 15 are reserved. Any access to them is an error. So is any register-space address whose offset is 64 or more.
- R9: An erroring read returns all zeros. An erroring write leaves the array and the registers unchanged.
- R10: An error from master ID 0 pulses `err_dsi`, and from any other ID pulses `err_mce`. The pulse lasts one cycle, together with `rsp_ready`, and the two never pulse together.
- R11: An access is aborted if `req_abort` is 1 with the strobe, or during the `ST_HOLD` cycle. An aborted access still pulses `rsp_ready`. It writes nothing, returns zero data and raises no error.
- R12: A strobe that arrives while the block is in `ST_HOLD` or `ST_RESP` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access strobe, one cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; top bit selects register space |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word |
| req_super | input | 1 | Supervisor-mode access |
| req_data | input | 1 | 1 = data access, 0 = instruction fetch |
| req_master | input | MASTER_W | Requesting master ID; 0 is the main CPU |
| req_abort | input | 1 | Cancels the access in progress |
| req_wdata | input | 32 | Write data in big-endian lanes |
| xlate_en | input | 1 | Enables region attribute checks |
| rsp_rdata | output | 32 | Read data, valid with `rsp_ready` |
| rsp_ready | output | 1 | Completion pulse |
| err_dsi | output | 1 | Error pulse for main-CPU accesses |
| err_mce | output | 1 | Error pulse for other masters |

## Verification
Suppose the state register took a wrong path, for example skipping `ST_HOLD` or lingering in `ST_RESP`. `rsp_ready` would then rise one cycle early or late, or stretch to two cycles, within the same access. A comparison every clock catches this at once. A corrupted mode or attribute register changes latency or error routing only on the next access. Storage damage from a wrongly committed write, whether errored, aborted or ignored, stays hidden until the damaged bytes are read back. The bench therefore re-reads every location it tried to corrupt.

// File: rtl/gsram_pkg.sv
package gsram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_RESP = 2'd2
    } state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam int REG_IMPL  = 12;   // implemented slots 0..11, 12..15 reserved
    localparam int ATTR_BITS = 3;    // {super_only, data_only, read_only}

    // bit k set => byte offset k within the word is addressed
    function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
        logic [3:0] m;
        case (sz)
            SZ_BYTE: m = 4'b0001 << off;
            SZ_HALF: m = 4'b0011 << off;
            SZ_WORD: m = 4'b1111;
            default: m = 4'b0000;
        endcase
        return m;
    endfunction

    // expand lane mask into a big-endian 32-bit bit mask
    function automatic logic [31:0] lane_bits(input logic [3:0] lanes);
        logic [31:0] b;
        for (int k = 0; k < 4; k++) b[31-8*k -: 8] = {8{lanes[k]}};
        return b;
    endfunction

endpackage

// File: rtl/gsram_access_check.sv
module gsram_access_check import gsram_pkg::*; #(
    parameter int NUM_REGIONS  = 2,
    parameter int REGION_BYTES = 1024,
    localparam int ARRAY_AW    = $clog2(NUM_REGIONS * REGION_BYTES),
    localparam int REGION_AW   = $clog2(REGION_BYTES),
    localparam int RIDX_W      = ARRAY_AW - REGION_AW,
    localparam int ADDR_W      = ARRAY_AW + 1,
    localparam int ATTR_W      = NUM_REGIONS * ATTR_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              write,
    input  logic              super_mode,
    input  logic              data_acc,
    input  logic              xlate,
    input  logic [ATTR_W-1:0] attrs,
    output logic              is_reg,
    output logic              fault
);
    logic             bad_size, misaligned, reg_fault;
    logic [NUM_REGIONS-1:0] region_viol;

    assign is_reg     = addr[ADDR_W-1];
    assign bad_size   = (size == 2'b11);
    assign misaligned = ((size == SZ_HALF) && addr[0]) ||
                        ((size == SZ_WORD) && (addr[1:0] != 2'b00));
    assign reg_fault  = (addr[ARRAY_AW-1:6] != '0) ||
                        (addr[5:2] >= 4'(REG_IMPL)) ||
                        !(super_mode && data_acc);

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        logic hit;
        assign hit = (addr[ARRAY_AW-1:REGION_AW] == RIDX_W'(r));
        assign region_viol[r] = hit && xlate &&
            ((attrs[3*r]   && write)      ||
             (attrs[3*r+1] && !data_acc)  ||
             (attrs[3*r+2] && !super_mode));
    end

    assign fault = bad_size || misaligned || (is_reg ? reg_fault : (|region_viol));

endmodule

// File: rtl/gsram_array.sv
module gsram_array #(
    parameter int WORDS = 512,
    localparam int WORD_AW = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [WORD_AW-1:0] widx,
    input  logic [3:0]         lanes,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata
);
    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int k = 0; k < 4; k++) begin
                if (lanes[k]) mem[widx][31-8*k -: 8] <= wdata[31-8*k -: 8];
            end
        end
    end

    assign rdata = mem[widx];

endmodule

// File: rtl/gsram_regfile.sv
module gsram_regfile import gsram_pkg::*; #(
    parameter int NUM_REGIONS = 2,
    localparam int ATTR_W     = NUM_REGIONS * ATTR_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [3:0]        slot,
    input  logic [3:0]        lanes,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              mode_two,
    output logic [ATTR_W-1:0] attrs
);
    logic [31:0] regs [REG_IMPL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_IMPL; i++) regs[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < REG_IMPL; i++) begin
                if (slot == 4'(i)) begin
                    for (int k = 0; k < 4; k++) begin
                        if (lanes[k]) regs[i][31-8*k -: 8] <= wdata[31-8*k -: 8];
                    end
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < REG_IMPL; i++) begin
            if (slot == 4'(i)) rdata = regs[i];
        end
    end

    assign mode_two = regs[0][0];
    assign attrs    = regs[1][ATTR_W-1:0];

endmodule

// File: rtl/guarded_sram_ctrl.sv
module guarded_sram_ctrl import gsram_pkg::*; #(
    parameter int NUM_REGIONS  = 2,
    parameter int REGION_BYTES = 1024,
    parameter int MASTER_W     = 2,
    parameter logic [MASTER_W-1:0] CPU_ID = '0,
    localparam int ARRAY_AW    = $clog2(NUM_REGIONS * REGION_BYTES),
    localparam int ADDR_W      = ARRAY_AW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic                req_super,
    input  logic                req_data,
    input  logic [MASTER_W-1:0] req_master,
    input  logic                req_abort,
    input  logic [31:0]         req_wdata,
    input  logic                xlate_en,
    output logic [31:0]         rsp_rdata,
    output logic                rsp_ready,
    output logic                err_dsi,
    output logic                err_mce
);
    localparam int WORDS   = (NUM_REGIONS * REGION_BYTES) / 4;
    localparam int WORD_AW = $clog2(WORDS);
    localparam int ATTR_W  = NUM_REGIONS * ATTR_BITS;

    typedef struct packed {
        logic                write;
        logic [ADDR_W-1:0]   addr;
        logic [1:0]          size;
        logic                sup;
        logic                dat;
        logic [MASTER_W-1:0] mst;
        logic                abort;
        logic [31:0]         wdata;
        logic                xl;
    } req_t;

    state_e state_q, state_d;
    req_t   live, held, cur;
    logic   mode_two, is_reg, fault, abort_now, exec, commit;
    logic [ATTR_W-1:0] attrs;
    logic [3:0]  lanes;
    logic [31:0] arr_rdata, reg_rdata, raw;
    logic [31:0] rdata_q;
    logic        dsi_q, mce_q;

    always_comb begin
        live = '{write: req_write, addr: req_addr, size: req_size, sup: req_super,
                 dat: req_data, mst: req_master, abort: req_abort,
                 wdata: req_wdata, xl: xlate_en};
        cur  = (state_q == ST_IDLE) ? live : held;
    end

    assign abort_now = cur.abort || req_abort;
    assign exec      = ((state_q == ST_IDLE) && req_valid && !mode_two) || (state_q == ST_HOLD);
    assign commit    = exec && cur.write && !fault && !abort_now;
    assign lanes     = lane_mask(cur.size, cur.addr[1:0]);
    assign raw       = is_reg ? reg_rdata : arr_rdata;

    gsram_access_check #(.NUM_REGIONS(NUM_REGIONS), .REGION_BYTES(REGION_BYTES)) u_check (
        .addr(cur.addr), .size(cur.size), .write(cur.write), .super_mode(cur.sup),
        .data_acc(cur.dat), .xlate(cur.xl), .attrs(attrs), .is_reg(is_reg), .fault(fault)
    );

    gsram_array #(.WORDS(WORDS)) u_array (
        .clk(clk), .we(commit && !is_reg), .widx(cur.addr[WORD_AW+1:2]),
        .lanes(lanes), .wdata(cur.wdata), .rdata(arr_rdata)
    );

    gsram_regfile #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(commit && is_reg), .slot(cur.addr[5:2]),
        .lanes(lanes), .wdata(cur.wdata), .rdata(reg_rdata),
        .mode_two(mode_two), .attrs(attrs)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            held    <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_IDLE) && req_valid) held <= live;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = mode_two ? ST_HOLD : ST_RESP;
            ST_HOLD: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            dsi_q   <= 1'b0;
            mce_q   <= 1'b0;
        end else if (exec) begin
            rdata_q <= (!fault && !abort_now && !cur.write) ? (raw & lane_bits(lanes)) : '0;
            dsi_q   <= fault && !abort_now && (cur.mst == CPU_ID);
            mce_q   <= fault && !abort_now && (cur.mst != CPU_ID);
        end else begin
            rdata_q <= '0;
            dsi_q   <= 1'b0;
            mce_q   <= 1'b0;
        end
    end

    assign rsp_ready = (state_q == ST_RESP);
    assign rsp_rdata = rdata_q;
    assign err_dsi   = dsi_q;
    assign err_mce   = mce_q;

    assert_err_with_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_dsi || err_mce) |-> rsp_ready);
    assert_err_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_dsi, err_mce}));
    assert_zero_on_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_dsi || err_mce) |-> (rsp_rdata == '0));
    assert_quiet_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ready |-> (rsp_rdata == '0));
    assert_hold_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> rsp_ready);
    assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |=> !rsp_ready);

endmodule

// File: tb/sim_guarded_sram_ctrl.sv
module sim_guarded_sram_ctrl;
    localparam logic [11:0] RB = 12'h800;   // register space base

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_super = 1, req_data = 1, req_abort = 0, xlate_en = 0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0, req_master = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic rsp_ready, err_dsi, err_mce;

    int n_checks = 0;
    int n_err = 0;

    // access attributes used by the next call
    logic c_sup = 1, c_dat = 1, c_xl = 0;
    logic [1:0] c_mid = 0;

    // reference model
    logic [7:0]  mem_m  [0:2047];
    logic [31:0] regs_m [0:11];

    always #5 clk = ~clk;

    guarded_sram_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_super(req_super), .req_data(req_data),
        .req_master(req_master), .req_abort(req_abort), .req_wdata(req_wdata),
        .xlate_en(xlate_en), .rsp_rdata(rsp_rdata), .rsp_ready(rsp_ready),
        .err_dsi(err_dsi), .err_mce(err_mce)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    task automatic acc(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input logic ab_e, input logic ab_l,
                       input logic poke, input string tag);
        int nb, off, slot, r, lane;
        logic e, two, ab;
        logic [2:0] at;
        logic [31:0] exp_rd;
        nb = 1 << sz; e = 0; slot = 0; exp_rd = '0;
        if (sz == 2'd3) e = 1;
        else if ((int'(a) % nb) != 0) e = 1;
        if (a >= RB) begin
            off = int'(a) - int'(RB);
            if (off >= 64) e = 1;
            else begin slot = off / 4; if (slot >= 12) e = 1; end
            if (!(c_sup && c_dat)) e = 1;
        end else begin
            r = int'(a) / 1024;
            at = 3'(regs_m[1] >> (3 * r));
            if (c_xl && ((at[0] && wr) || (at[1] && !c_dat) || (at[2] && !c_sup))) e = 1;
        end
        two = regs_m[0][0];
        ab = ab_e | (two & ab_l);
        if (!e && !ab) begin
            for (int b = 0; b < nb; b++) begin
                lane = (int'(a) % 4) + b;
                if (a >= RB) begin
                    if (wr) regs_m[slot][31-8*lane -: 8] = wd[31-8*lane -: 8];
                    else exp_rd[31-8*lane -: 8] = regs_m[slot][31-8*lane -: 8];
                end else begin
                    if (wr) mem_m[int'(a) + b] = wd[31-8*lane -: 8];
                    else exp_rd[31-8*lane -: 8] = mem_m[int'(a) + b];
                end
            end
        end
        // drive
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        req_super = c_sup; req_data = c_dat; req_master = c_mid; xlate_en = c_xl; req_abort = ab_e;
        @(negedge clk);
        req_valid = 0; req_abort = ab_l;
        if (poke) begin
            req_valid = 1; req_write = 1; req_addr = 12'h3F0; req_size = 2'd2;
            req_wdata = 32'hDEADBEEF; req_super = 1; req_data = 1; xlate_en = 0;
        end
        if (two) begin
            chk(tag, "wait ready", {31'd0, rsp_ready}, 32'd0);
            chk(tag, "wait rdata", rsp_rdata, 32'd0);
            chk(tag, "wait errs", {30'd0, err_dsi, err_mce}, 32'd0);
            @(negedge clk);
            req_valid = 0; req_abort = 0;
        end
        chk(tag, "ready", {31'd0, rsp_ready}, 32'd1);
        chk(tag, "rdata", rsp_rdata, exp_rd);
        chk(tag, "err_dsi", {31'd0, err_dsi}, {31'd0, e && !ab && (c_mid == 0)});
        chk(tag, "err_mce", {31'd0, err_mce}, {31'd0, e && !ab && (c_mid != 0)});
        @(negedge clk);
        req_valid = 0; req_abort = 0;
        chk(tag, "ready after", {31'd0, rsp_ready}, 32'd0);
        chk(tag, "rdata after", rsp_rdata, 32'd0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d, input string tag);
        acc(1, a, sz, d, 0, 0, 0, tag);
    endtask
    task automatic rd(input logic [11:0] a, input logic [1:0] sz, input string tag);
        acc(0, a, sz, 32'h0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) mem_m[i] = 8'h00;
        for (int i = 0; i < 12; i++) regs_m[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "ready", {31'd0, rsp_ready}, 32'd0);
        chk("R1", "errs", {30'd0, err_dsi, err_mce}, 32'd0);
        chk("R1", "rdata", rsp_rdata, 32'd0);
        rst_n = 1;
        rd(RB + 12'h0, 2'd2, "R1");
        rd(RB + 12'h4, 2'd2, "R1");

        // R2/R4: one-cycle accesses, lanes
        wr(12'h000, 2'd2, 32'h11223344, "R2");
        rd(12'h000, 2'd2, "R2");
        rd(12'h001, 2'd0, "R4");
        rd(12'h003, 2'd0, "R4");
        wr(12'h002, 2'd1, 32'h0000BEEF, "R4");
        wr(12'h000, 2'd0, 32'hA5000000, "R4");
        rd(12'h000, 2'd2, "R4");
        rd(12'h002, 2'd1, "R4");
        wr(12'h010, 2'd2, 32'hCAFEF00D, "R4");
        wr(12'h3F0, 2'd2, 32'h01020304, "R4");
        wr(12'h404, 2'd2, 32'h55667788, "R4");

        // R5/R9: misaligned and bad size
        wr(12'h011, 2'd1, 32'hFFFFFFFF, "R5");
        wr(12'h012, 2'd2, 32'hFFFFFFFF, "R5");
        rd(12'h013, 2'd1, "R5");
        rd(12'h010, 2'd3, "R5");
        rd(12'h010, 2'd2, "R9");

        // R7/R10: register privilege and error routing
        c_sup = 0; wr(RB + 12'h14, 2'd2, 32'h12345678, "R7"); c_sup = 1;
        c_dat = 0; rd(RB + 12'h14, 2'd2, "R7"); c_dat = 1;
        c_mid = 2; c_sup = 0; rd(RB + 12'h0, 2'd2, "R10"); c_sup = 1; c_mid = 0;
        wr(RB + 12'h14, 2'd2, 32'h0BADC0DE, "R7");
        wr(RB + 12'h15, 2'd0, 32'h00EE0000, "R4");
        rd(RB + 12'h14, 2'd2, "R9");

        // R8: reserved slots and out-of-range offsets
        wr(RB + 12'h30, 2'd2, 32'hFFFFFFFF, "R8");
        rd(RB + 12'h3C, 2'd2, "R8");
        c_mid = 1; rd(RB + 12'h40, 2'd2, "R8"); c_mid = 0;
        rd(RB + 12'h2C, 2'd2, "R8");

        // R6: region attributes (region0 read-only, region1 data+super only)
        wr(RB + 12'h4, 2'd2, 32'h00000031, "R6");
        c_xl = 0; wr(12'h020, 2'd2, 32'h0F0F0F0F, "R6");
        c_xl = 1; wr(12'h020, 2'd2, 32'hF0F0F0F0, "R6");
        rd(12'h020, 2'd2, "R6");
        c_sup = 0; rd(12'h404, 2'd2, "R6"); c_sup = 1;
        c_dat = 0; c_mid = 3; rd(12'h404, 2'd2, "R10"); c_dat = 1; c_mid = 0;
        rd(12'h404, 2'd2, "R6");
        c_xl = 0; c_sup = 0; rd(12'h404, 2'd2, "R6"); c_sup = 1;

        // R11: abort in one-cycle mode
        acc(1, 12'h010, 2'd2, 32'h99999999, 1, 0, 0, "R11");
        acc(0, 12'h010, 2'd2, 32'h0, 1, 0, 0, "R11");
        c_sup = 0; acc(0, RB, 2'd2, 32'h0, 1, 0, 0, "R11"); c_sup = 1;
        rd(12'h010, 2'd2, "R11");

        // R12: strobe during response in one-cycle mode
        acc(0, 12'h000, 2'd2, 32'h0, 0, 0, 1, "R12");
        rd(12'h3F0, 2'd2, "R12");

        // R3: two-cycle mode
        wr(RB + 12'h0, 2'd2, 32'h00000001, "R3");
        rd(12'h000, 2'd2, "R3");
        wr(12'h030, 2'd1, 32'h77770000, "R3");
        rd(12'h030, 2'd1, "R3");
        c_mid = 2; rd(12'h031, 2'd2, "R3"); c_mid = 0;
        rd(12'h031, 2'd1, "R5");
        acc(1, 12'h010, 2'd2, 32'h44444444, 0, 1, 0, "R11");
        acc(1, 12'h010, 2'd2, 32'h44444444, 1, 0, 0, "R11");
        rd(12'h010, 2'd2, "R11");
        acc(0, 12'h000, 2'd2, 32'h0, 0, 0, 1, "R12");
        rd(12'h3F0, 2'd2, "R12");
        wr(RB + 12'h0, 2'd0, 32'h00000000, "R3");
        wr(RB + 12'h3, 2'd0, 32'h00000000, "R3");
        rd(12'h000, 2'd2, "R3");

        summary();
        $finish;
    end

endmodule